// File: doc/BRIEF.md
# Short Branch Condition and Flag Update Unit

This unit resolves the short-format conditional instructions that share one 4-bit selector space. Depending on the selector, an issued instruction is a conditional branch, one of three flag updates, or a supervisor call. Branches test the current condition codes (low, equal, high, overflow, carry). They produce a one-cycle taken pulse and a target address. The target is the address of the following instruction plus a sign-extended 8-bit field counted in 16-bit units.

The flag instructions read a condition code from the low nibble of the same 8-bit field. They then update a single program flag in one of three ways:
- assign: the flag takes the result of the condition;
- set-only: the flag goes to one when the condition holds;
- clear-only: the flag goes to zero when the condition holds.

The supervisor-call selector raises a one-cycle trap request. None of these instructions writes the condition codes. Fetch, flushing and trap handling belong to the surrounding pipeline.

Top module: `bcu_branch_flag_unit`

## Requirements
- R1: While reset is asserted and after its release with no instruction issued, taken_o, trap_o and flag_o are 0 and target_o is 0.
- R2: Selector values 1 low, 2 equal, 3 low-or-equal, 4 high, 5 not-equal, 6 high-or-equal, 7 no-overflow, 8 overflow, 10 carry and 11 no-carry are branches. One cycle after issue, taken_o is 1 exactly when the named condition holds on the condition inputs.
- R3: Selector 15 is an unconditional branch. taken_o is 1 one cycle after issue, whatever the condition inputs are.
- R4: One cycle after any branch selector is issued, target_o equals pc_next_i + 2 × (field_i read as a signed 8-bit value), modulo 2^ADDR_W.
- R5: Selector 0 writes the flag with 1 when the condition coded in field_i[3:0] holds and with 0 otherwise.
- R6: Selector 12 writes the flag with 1 when the condition coded in field_i[3:0] holds and leaves it unchanged otherwise.
- R7: Selector 13 writes the flag with 0 when the condition coded in field_i[3:0] holds and leaves it unchanged otherwise.
- R8: Selector 14 makes trap_o 1 for one cycle after issue. It does not raise taken_o and does not change the flag.
- R9: taken_o and trap_o are single-cycle pulses that follow an issued instruction. Without valid_i the flag holds its value. A branch never changes the flag, and a flag or trap selector never raises taken_o.
- R10: A flag instruction uses the branch codes of R2/R3 in field_i[3:0]. Codes 0, 9, 12, 13 and 14 count as a condition that does not hold, and field_i[7:4] has no effect on the flag.
- R11: Selector 9 is unused. It raises neither taken_o nor trap_o and leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction is issued this cycle |
| sel_i | input | 4 | Selector field of the instruction |
| field_i | input | 8 | Displacement (branches) or condition code in bits 3:0 (flag instructions) |
| pc_next_i | input | ADDR_W | Address of the instruction after the issued one |
| cc_low_i | input | 1 | Condition code: low |
| cc_eq_i | input | 1 | Condition code: equal |
| cc_high_i | input | 1 | Condition code: high |
| cc_ovf_i | input | 1 | Condition code: overflow |
| cc_carry_i | input | 1 | Condition code: carry |
| taken_o | output | 1 | Branch taken pulse, one cycle after issue |
| target_o | output | ADDR_W | Branch target, loaded on every branch issue |
| trap_o | output | 1 | Supervisor call request pulse |
| flag_o | output | 1 | Program flag |

## Verification
The sweep covers every selector against all 32 combinations of the five condition inputs. For each combination it uses both starting values of the flag and all 16 codes in the low field nibble. This separates the assign, set-only and clear-only updates, which differ only when the condition fails or when the flag already has the written value. Branch fields alternate their sign bit and their upper nibble, so the sign extension, the 16-bit scaling and wrap-around of the target are exercised. Varying the upper nibble on flag instructions also shows that only the low nibble picks the condition. A following idle cycle confirms that the taken and trap pulses fall back to zero.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  typedef enum logic [3:0] {
    SEL_CTF = 4'd0,
    SEL_LO  = 4'd1,
    SEL_EQ  = 4'd2,
    SEL_LE  = 4'd3,
    SEL_HI  = 4'd4,
    SEL_NE  = 4'd5,
    SEL_HE  = 4'd6,
    SEL_NOV = 4'd7,
    SEL_OV  = 4'd8,
    SEL_RSV = 4'd9,
    SEL_CY  = 4'd10,
    SEL_NCY = 4'd11,
    SEL_SFC = 4'd12,
    SEL_CFC = 4'd13,
    SEL_SVC = 4'd14,
    SEL_ALW = 4'd15
  } sel_e;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_BRANCH = 3'd1,
    K_FASSGN = 3'd2,
    K_FSET   = 3'd3,
    K_FCLR   = 3'd4,
    K_TRAP   = 3'd5
  } kind_e;

  typedef struct packed {
    logic lo;
    logic eq;
    logic hi;
    logic ov;
    logic cy;
  } cc_t;

endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
(
  input  sel_e code_i,
  input  cc_t  cc_i,
  output logic hold_o
);

  always_comb begin
    hold_o = 1'b0;
    case (code_i)
      SEL_LO:  hold_o = cc_i.lo;
      SEL_EQ:  hold_o = cc_i.eq;
      SEL_LE:  hold_o = cc_i.lo | cc_i.eq;
      SEL_HI:  hold_o = cc_i.hi;
      SEL_NE:  hold_o = ~cc_i.eq;
      SEL_HE:  hold_o = cc_i.hi | cc_i.eq;
      SEL_NOV: hold_o = ~cc_i.ov;
      SEL_OV:  hold_o = cc_i.ov;
      SEL_CY:  hold_o = cc_i.cy;
      SEL_NCY: hold_o = ~cc_i.cy;
      SEL_ALW: hold_o = 1'b1;
      default: hold_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bcu_decode.sv
module bcu_decode
  import bcu_pkg::*;
(
  input  sel_e  sel_i,
  output kind_e kind_o
);

  always_comb begin
    case (sel_i)
      SEL_CTF: kind_o = K_FASSGN;
      SEL_SFC: kind_o = K_FSET;
      SEL_CFC: kind_o = K_FCLR;
      SEL_SVC: kind_o = K_TRAP;
      SEL_RSV: kind_o = K_NONE;
      default: kind_o = K_BRANCH;
    endcase
  end

endmodule

// File: rtl/bcu_target_gen.sv
module bcu_target_gen #(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 8,
  parameter int UNIT_SHIFT = 1
) (
  input  logic [ADDR_W-1:0] pc_next_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    offset   = disp_ext << UNIT_SHIFT;
    target_o = pc_next_i + offset;
  end

endmodule

// File: rtl/bcu_flag_ctl.sv
module bcu_flag_ctl
  import bcu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  kind_e kind_i,
  input  logic  cond_i,
  output logic  flag_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (en_i) begin
      case (kind_i)
        K_FASSGN: flag_d = cond_i;
        K_FSET:   if (cond_i) flag_d = 1'b1;
        K_FCLR:   if (cond_i) flag_d = 1'b0;
        default:  flag_d = flag_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R6
  set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && kind_i == K_FSET && flag_q) |=> flag_q);

  // R7
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && kind_i == K_FCLR && !flag_q) |=> !flag_q);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> $stable(flag_q));

endmodule

// File: rtl/bcu_branch_flag_unit.sv
module bcu_branch_flag_unit
  import bcu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [3:0]        sel_i,
  input  logic [DISP_W-1:0] field_i,
  input  logic [ADDR_W-1:0] pc_next_i,
  input  logic              cc_low_i,
  input  logic              cc_eq_i,
  input  logic              cc_high_i,
  input  logic              cc_ovf_i,
  input  logic              cc_carry_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              trap_o,
  output logic              flag_o
);

  localparam int N_EVAL = 2;

  sel_e  sel;
  kind_e kind;
  cc_t   cc;
  sel_e  codes [N_EVAL];
  logic  holds [N_EVAL];

  logic              taken_q, taken_d;
  logic              trap_q, trap_d;
  logic [ADDR_W-1:0] target_q, target_d, target_calc;
  logic              tgt_en;

  always_comb begin
    sel      = sel_e'(sel_i);
    cc       = '{lo: cc_low_i, eq: cc_eq_i, hi: cc_high_i, ov: cc_ovf_i, cy: cc_carry_i};
    codes[0] = sel;
    codes[1] = sel_e'(field_i[3:0]);
  end

  bcu_decode i_decode (
    .sel_i  (sel),
    .kind_o (kind)
  );

  // index 0 tests the branch condition, index 1 the flag condition
  for (genvar g = 0; g < N_EVAL; g++) begin : g_eval
    bcu_cond_eval i_eval (
      .code_i (codes[g]),
      .cc_i   (cc),
      .hold_o (holds[g])
    );
  end

  bcu_target_gen #(
    .ADDR_W     (ADDR_W),
    .DISP_W     (DISP_W),
    .UNIT_SHIFT (1)
  ) i_target (
    .pc_next_i (pc_next_i),
    .disp_i    (field_i),
    .target_o  (target_calc)
  );

  bcu_flag_ctl i_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (valid_i),
    .kind_i (kind),
    .cond_i (holds[1]),
    .flag_o (flag_o)
  );

  always_comb begin
    tgt_en   = valid_i && (kind == K_BRANCH);
    taken_d  = tgt_en && holds[0];
    trap_d   = valid_i && (kind == K_TRAP);
    target_d = tgt_en ? target_calc : target_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q  <= 1'b0;
      trap_q   <= 1'b0;
      target_q <= '0;
    end else begin
      taken_q  <= taken_d;
      trap_q   <= trap_d;
      target_q <= target_d;
    end
  end

  assign taken_o  = taken_q;
  assign trap_o   = trap_q;
  assign target_o = target_q;

  // R3
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sel_i == 4'd15) |=> taken_o);

  // R8
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken_o && trap_o));

  // R8
  trap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(valid_i && sel_i == 4'd14));

  // R9
  taken_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> $past(valid_i));

  // R11
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sel_i == 4'd9) |=> (!taken_o && !trap_o));

endmodule

// File: tb/test_bcu_branch_flag_unit.sv
module test_bcu_branch_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [3:0]  sel_i;
  logic [7:0]  field_i;
  logic [31:0] pc_next_i;
  logic        cc_low_i, cc_eq_i, cc_high_i, cc_ovf_i, cc_carry_i;
  logic        taken_o, trap_o, flag_o;
  logic [31:0] target_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bcu_branch_flag_unit i_bcu_branch_flag_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .sel_i(sel_i),
    .field_i(field_i), .pc_next_i(pc_next_i),
    .cc_low_i(cc_low_i), .cc_eq_i(cc_eq_i), .cc_high_i(cc_high_i),
    .cc_ovf_i(cc_ovf_i), .cc_carry_i(cc_carry_i),
    .taken_o(taken_o), .target_o(target_o), .trap_o(trap_o), .flag_o(flag_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit cond_of(input int code, input logic [4:0] c);
    // c = {lo, eq, hi, ov, cy}
    case (code)
      1:  return c[4];
      2:  return c[3];
      3:  return c[4] | c[3];
      4:  return c[2];
      5:  return !c[3];
      6:  return c[2] | c[3];
      7:  return !c[1];
      8:  return c[1];
      10: return c[0];
      11: return !c[0];
      15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit is_branch(input int s);
    return !(s == 0 || s == 9 || s == 12 || s == 13 || s == 14);
  endfunction

  task automatic issue(input logic [3:0] s, input logic [7:0] f, input logic [31:0] pc, input logic [4:0] c);
    @(negedge clk);
    valid_i = 1'b1; sel_i = s; field_i = f; pc_next_i = pc;
    {cc_low_i, cc_eq_i, cc_high_i, cc_ovf_i, cc_carry_i} = c;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=<190000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; sel_i = '0; field_i = '0; pc_next_i = '0;
    {cc_low_i, cc_eq_i, cc_high_i, cc_ovf_i, cc_carry_i} = '0;
    repeat (3) @(negedge clk);
    check(!taken_o && !trap_o && !flag_o && target_o == 0, "R1 in reset",
          {taken_o, trap_o, flag_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!taken_o && !trap_o && !flag_o && target_o == 0, "R1 after release",
          {taken_o, trap_o, flag_o}, 0);

    for (int s = 0; s < 16; s++) begin
      for (int cv = 0; cv < 32; cv++) begin
        for (int f0 = 0; f0 < 2; f0++) begin
          for (int code = 0; code < 16; code++) begin
            logic [7:0]  fld;
            logic [31:0] pc;
            logic [31:0] exp_tgt;
            bit          c;
            bit          exp_flag;
            fld = {f0[0], cv[2:0], code[3:0]};
            pc  = 32'h7FFF_FF80 ^ {cv[4:0], code[3:0], s[3:0], 4'h0} ^ (f0 == 1 ? 32'h8000_007C : 32'h0);
            // set the starting flag: assign with always (15) or never (0)
            issue(4'd0, f0 ? 8'h0F : 8'hF0, 32'h0, cv[4:0]);
            check(flag_o == f0[0], "R5 flag init", {31'b0, flag_o}, f0);
            issue(s[3:0], fld, pc, cv[4:0]);
            exp_flag = f0[0];
            if (is_branch(s)) begin
              c = cond_of(s, cv[4:0]);
              exp_tgt = pc + ({{24{fld[7]}}, fld} << 1);
              check(taken_o == c, s == 15 ? "R3 always taken" : "R2 branch taken",
                    {31'b0, taken_o}, {31'b0, c});
              check(target_o == exp_tgt, "R4 target", target_o, exp_tgt);
              check(trap_o == 1'b0, "R9 no trap on branch", {31'b0, trap_o}, 0);
            end else begin
              c = cond_of(code, cv[4:0]);
              if (s == 0) exp_flag = c;
              else if (s == 12 && c) exp_flag = 1'b1;
              else if (s == 13 && c) exp_flag = 1'b0;
              check(taken_o == 1'b0, "R9 no taken on non-branch", {31'b0, taken_o}, 0);
              check(trap_o == (s == 14), s == 14 ? "R8 trap raised" : "R11 no trap",
                    {31'b0, trap_o}, {31'b0, s == 14});
            end
            check(flag_o == exp_flag,
                  s == 0 ? "R5 assign flag" : s == 12 ? "R6 set-only flag" :
                  s == 13 ? "R7 clear-only flag" : s == 9 ? "R11 unused keeps flag" :
                  s == 14 ? "R8 trap keeps flag" : "R10 flag code / R9 branch keeps flag",
                  {31'b0, flag_o}, {31'b0, exp_flag});
            if (s == 14 || s == 15) begin
              @(negedge clk);
              check(!taken_o && !trap_o && flag_o == exp_flag, "R9 pulse ends",
                    {taken_o, trap_o, flag_o}, {2'b0, exp_flag});
            end
          end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule